// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block turns one byte and an extra ninth bit into an eleven-bit asynchronous frame on a single output line. The frame is a low start bit, the eight data bits least significant first, the ninth bit, and a high stop bit. The caller supplies the ninth bit with each write. It can carry a parity bit computed elsewhere or a flag that marks an address byte.

Bit timing comes from two counters that run freely from reset. A prescaler divides the system clock by 2 or by 4, chosen by `rate_sel`. A sixteen-step sub-counter counts prescaler ticks. A write does not start the line at once. The block waits for the next wrap of the sixteen-step counter and then waits a fixed number of clock cycles more, so every frame begins at the same phase of the bit clock. A sticky completion flag rises when the stop bit goes onto the line and stays high until an explicit clear.

Top module: `uart9_tx`

## Requirements
- R1: Out of reset, `tx_line` is 1, `busy` is 0 and `tx_done` is 0. While `busy` is 0 the line stays at 1.
- R2: An accepted write captures `wr_data` and `wr_ninth`. The frame sent is bit 0 = 0 (start), then `wr_data[0]` through `wr_data[7]`, then the captured ninth bit, then bit 10 = 1 (stop).
- R3: Each frame bit holds the line for exactly 16*D system clock cycles. D is 2 when `rate_sel` = 0 and 4 when `rate_sel` = 1. `rate_sel` may change only while `rst` is high.
- R4: Number the cycles after reset release from 0. A wrap cycle is any cycle c with c mod 16*D = 16*D-1. Let the write be sampled at the end of cycle e. Let k be the first wrap cycle with k > e. The start bit then first appears in cycle k+1+START_DELAY, where START_DELAY defaults to 5. A write sampled in a wrap cycle waits for the next wrap.
- R5: `tx_done` rises in the same cycle that the stop bit first appears on the line.
- R6: `tx_done` stays at 1 until `done_clr` is sampled high, and it reads 0 in the following cycle. A new write does not clear it. If a set and a clear fall in the same cycle, the set wins.
- R7: A write is accepted only while `busy` is 0. `busy` is 1 from the cycle after the accepted write until the stop bit ends. A write while `busy` is 1 changes neither the frame in progress nor anything after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 4 |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Byte to send |
| wr_ninth | input | 1 | Ninth frame bit, captured with the write |
| done_clr | input | 1 | Clears the completion flag |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is waiting to start or is being sent |
| tx_done | output | 1 | Sticky flag, set when the stop bit is driven |

## Verification
The bench uses the default widths: 8 data bits, a sixteen-step sub-counter, prescale factors 2 and 4, and a start offset of 5. It runs one pass per prescale factor, changing `rate_sel` during a reset, so both 32-cycle and 64-cycle bits are exercised. Writes are placed both in the wrap cycle itself and in the cycle just before it. This places the start exactly one bit period apart between those two cases. Random bytes, ninth bits, idle gaps, flag clears and mid-frame writes are checked cycle by cycle against a model built from the counter numbering in R4.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  // Transmitter sequencing states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // line high, ready for a write
    ST_WAIT = 2'd1,   // frame latched, waiting for aligned start
    ST_SEND = 2'd2    // shifting frame bits
  } tx_state_e;
endpackage

// File: rtl/uart9_baud.sv
// Free-running prescaler and sixteen-step sub-counter; flags the wrap cycle.
module uart9_baud #(
  parameter int OVS    = 16,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  output logic roll
);
  localparam int PRE_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [SUB_W-1:0] sub_cnt;
  logic [PRE_W-1:0] pre_last;
  logic             tick;

  assign pre_last = rate_sel ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
  assign tick     = (pre_cnt == pre_last);
  assign roll     = tick && (sub_cnt == SUB_W'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else begin
      if (tick) begin
        pre_cnt <= '0;
        if (sub_cnt == SUB_W'(OVS - 1)) sub_cnt <= '0;
        else                            sub_cnt <= sub_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart9_align.sv
// Turns each wrap into a bit boundary a fixed number of cycles later.
module uart9_align #(
  parameter int START_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic roll,
  input  logic arm_en,
  output logic bound
);
  localparam int DLY_W = $clog2(START_DELAY + 1);

  logic [DLY_W-1:0] dly;
  logic             act;

  assign bound = act && (dly == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dly <= '0;
      act <= 1'b0;
    end else if (roll && arm_en) begin
      act <= 1'b1;
      dly <= DLY_W'(START_DELAY - 1);
    end else if (act) begin
      if (dly == '0) act <= 1'b0;
      else           dly <= dly - 1'b1;
    end
  end
endmodule

// File: rtl/uart9_frame.sv
// Frame capture, bit sequencing, line driver and completion flag.
module uart9_frame
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              done_clr,
  input  logic              bound,
  output logic              arm_en,
  output logic              tx_line,
  output logic              busy,
  output logic              tx_done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int LAST    = FRAME_W - 1;

  tx_state_e          state;
  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]   idx;
  logic               line_q;
  logic               done_q;
  logic               set_done;

  assign arm_en  = (state != ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign tx_line = line_q;
  assign tx_done = done_q;
  assign set_done = bound && (state == ST_SEND) && (idx == IDX_W'(LAST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sh     <= '1;
      idx    <= '0;
      line_q <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (wr_stb) begin
            sh    <= {1'b1, wr_ninth, wr_data, 1'b0};
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bound) begin
            line_q <= sh[0];
            sh     <= {1'b1, sh[FRAME_W-1:1]};
            idx    <= '0;
            state  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (bound) begin
            if (idx == IDX_W'(LAST)) begin
              line_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              line_q <= sh[0];
              sh     <= {1'b1, sh[FRAME_W-1:1]};
              idx    <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done_q <= 1'b0;
    else if (set_done) done_q <= 1'b1;
    else if (done_clr) done_q <= 1'b0;
  end
endmodule

// File: rtl/uart9_tx.sv
// Nine-bit asynchronous transmitter top level.
module uart9_tx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int DIV_LO      = 2,
  parameter int DIV_HI      = 4,
  parameter int START_DELAY = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_sel,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              done_clr,
  output logic              tx_line,
  output logic              busy,
  output logic              tx_done
);
  logic roll;
  logic bound;
  logic arm_en;

  uart9_baud #(.OVS(OVS), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) baud_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .roll(roll)
  );

  uart9_align #(.START_DELAY(START_DELAY)) align_i (
    .clk(clk), .rst(rst), .roll(roll), .arm_en(arm_en), .bound(bound)
  );

  uart9_frame #(.DATA_W(DATA_W)) frame_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_ninth(wr_ninth), .done_clr(done_clr), .bound(bound),
    .arm_en(arm_en), .tx_line(tx_line), .busy(busy), .tx_done(tx_done)
  );
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk #(
  parameter int OVS    = 16,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 4
) (
  input logic clk,
  input logic rst,
  input logic rate_sel,
  input logic wr_stb,
  input logic done_clr,
  input logic tx_line,
  input logic busy,
  input logic tx_done
);
  localparam int P_LO = OVS * DIV_LO;
  localparam int P_HI = OVS * DIV_HI;

  logic        line_q;
  logic        started;
  logic [15:0] run;
  logic [15:0] p_cur;
  logic        chg;

  assign p_cur = rate_sel ? 16'(P_HI) : 16'(P_LO);
  assign chg   = (tx_line != line_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b1;
      started <= 1'b0;
      run     <= '0;
    end else begin
      line_q <= tx_line;
      if (chg) run <= 16'd1;
      else     run <= run + 16'd1;
      if (!busy)                         started <= 1'b0;
      else if (chg && !tx_line)          started <= 1'b1;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);

  // R3
  bit_len_chk: assert property (@(posedge clk) disable iff (rst)
    (started && chg) |-> ((run % p_cur) == 16'd0));

  // R5
  done_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (busy && tx_line));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !done_clr) |=> tx_done);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy) |=> busy);
endmodule

bind uart9_tx uart9_tx_chk #(.OVS(OVS), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) chk_i (
  .clk(clk), .rst(rst), .rate_sel(rate_sel), .wr_stb(wr_stb),
  .done_clr(done_clr), .tx_line(tx_line), .busy(busy), .tx_done(tx_done)
);

// File: tb/uart9_tx_tb_top.sv
`timescale 1ns/1ps
module uart9_tx_tb_top;
  localparam int DATA_W = 8;
  localparam int SD     = 5;
  localparam int FW     = DATA_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rate_sel = 1'b0;
  logic wr_stb = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ninth = 1'b0;
  logic done_clr = 1'b0;
  logic tx_line, busy, tx_done;

  int cyc;
  int tests = 0;
  int fails = 0;
  int p_per = 32;
  logic exp_done = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  uart9_tx #(.DATA_W(DATA_W), .START_DELAY(SD)) dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_ninth(wr_ninth), .done_clr(done_clr),
    .tx_line(tx_line), .busy(busy), .tx_done(tx_done)
  );

  function automatic logic exp_line(int c, int s, int p, logic [FW-1:0] f);
    if (c < s || c >= s + FW * p) return 1'b1;
    return f[(c - s) / p];
  endfunction

  function automatic int first_wrap(int e, int p);
    int k;
    k = e + 1;
    while ((k % p) != p - 1) k++;
    return k;
  endfunction

  task automatic check1(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset(logic rs);
    @(negedge clk);
    rst = 1'b1; rate_sel = rs; wr_stb = 0; done_clr = 0;
    p_per = rs ? 64 : 32;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_done = 1'b0;
    // R1 reset state
    check1("R1 line", tx_line, 1'b1);
    check1("R1 busy", busy, 1'b0);
    check1("R1 done", tx_done, 1'b0);
  endtask

  task automatic clear_flag();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    exp_done = 1'b0;
    check1("R6 clear", tx_done, 1'b0);
  endtask

  // phase < 0: write now; mid > 0: ignored write mid-frame (R7)
  task automatic send_frame(logic [DATA_W-1:0] d, logic n9, int phase, int mid);
    int e, k, s, p, bad_c;
    logic [FW-1:0] f;
    logic lb, db, bb, el, ed, eb, al, ad, ab;
    p = p_per;
    if (phase >= 0) while ((cyc % p) != phase) @(negedge clk);
    e = cyc;
    wr_stb = 1'b1; wr_data = d; wr_ninth = n9;
    f = {1'b1, n9, d, 1'b0};
    k = first_wrap(e, p);
    s = k + 1 + SD;
    lb = 0; db = 0; bb = 0; bad_c = 0;
    el = 1; ed = 0; eb = 0; al = 1; ad = 0; ab = 0;
    @(negedge clk);
    while (cyc < s + FW * p + 3) begin
      if (tx_line !== exp_line(cyc, s, p, f) && !lb) begin
        lb = 1; el = exp_line(cyc, s, p, f); al = tx_line; bad_c = cyc;
      end
      if (tx_done !== ((cyc >= s + (FW - 1) * p) ? 1'b1 : exp_done) && !db) begin
        db = 1; ed = (cyc >= s + (FW - 1) * p) ? 1'b1 : exp_done; ad = tx_done;
      end
      if (busy !== (cyc < s + FW * p) && !bb) begin
        bb = 1; eb = (cyc < s + FW * p); ab = busy;
      end
      wr_stb   = (mid > 0) && (cyc == e + 1 + mid);
      wr_data  = ~d;
      wr_ninth = ~n9;
      @(negedge clk);
    end
    wr_stb = 1'b0;
    exp_done = 1'b1;
    // R2 R3 R4: bit order, bit period, start alignment
    tests++;
    if (lb) begin
      fails++;
      $display("FAIL R2/R3/R4 line at cycle %0d: actual %0b expected %0b (data %h ninth %0b)",
               bad_c, al, el, d, n9);
    end
    // R5 R6 flag timing and hold
    tests++;
    if (db) begin
      fails++;
      $display("FAIL R5/R6 done: actual %0b expected %0b", ad, ed);
    end
    // R7 busy window, ignored writes
    tests++;
    if (bb) begin
      fails++;
      $display("FAIL R7 busy: actual %0b expected %0b", ab, eb);
    end
  endtask

  task automatic random_frames(int cnt);
    for (int i = 0; i < cnt; i++) begin
      logic [DATA_W-1:0] d;
      int mid;
      d = DATA_W'($urandom);
      mid = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 300) : 0;
      if ($urandom_range(0, 2) == 0) clear_flag();
      repeat ($urandom_range(0, 40)) @(negedge clk);
      send_frame(d, 1'($urandom), -1, mid);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    do_reset(1'b0);
    // R4 write sampled in the wrap cycle waits a full period
    send_frame(8'h00, 1'b1, 31, 0);
    // R4 write one cycle before wrap; R6 flag survives a new write; R7 mid-write
    send_frame(8'hFF, 1'b0, 30, 100);
    clear_flag();
    check1("R6 hold after clear", tx_done, 1'b0);
    send_frame(8'h5A, 1'b1, -1, 0);
    random_frames(8);
    do_reset(1'b1);
    send_frame(8'hA5, 1'b1, 63, 0);
    send_frame(8'h01, 1'b0, 62, 250);
    random_frames(6);
    @(negedge clk);
    check1("R1 idle line", tx_line, 1'b1);
    check1("R1 idle busy", busy, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule